// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic unit of an 8-bit accumulator machine. On every clock it takes the accumulator, an operand, the current status byte and a 3-bit operation code. It registers the result and the updated status byte. The operations are add with carry, bitwise AND, OR and XOR, and four single-bit moves of the accumulator: shift left, shift right, rotate left and rotate right.

Each operation rewrites only the flags it owns. Every other status bit is copied from the incoming status byte, so the surrounding core can feed the whole byte through without masking it. The status byte is laid out from bit 7 down to bit 0 as: negative (N), overflow (V), spare, break, decimal, interrupt-disable, zero (Z), carry (C). The data width is a parameter whose default is 8. The status byte is always 8 bits.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, `res_o` and `st_o` are 0.
- R2: `res_o` and `st_o` reflect the inputs sampled at the previous rising clock edge, so the latency is one cycle.
- R3: Operation code 0 (add) gives `res_o` = the low byte of acc + operand + st_i[0]. st_o[0] (C) is the carry out of the top bit.
- R4: For the add, st_o[6] (V) is 1 exactly when acc and operand have equal sign bits and the result's sign bit differs from them. Otherwise V is 0.
- R5: Operation codes 1, 2 and 3 give the bitwise AND, OR and XOR of acc and operand. They leave V (bit 6) and C (bit 0) equal to st_i.
- R6: Operation code 4 (shift left) moves acc left by one with 0 entering bit 0. The old top bit goes to C.
- R7: Operation code 5 (shift right) moves acc right by one with 0 entering the top bit. The old bit 0 goes to C, so N is always 0.
- R8: Operation codes 6 and 7 (rotate left and right) move the incoming C into the vacated end bit. The bit moved out goes to C.
- R9: For every operation, Z (bit 1) is 1 exactly when the result is zero, and N (bit 7) equals the result's top bit.
- R10: Status bits 5 to 2 always equal st_i. V equals st_i for every operation except add. The shift and rotate operations ignore the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code (0 add, 1 and, 2 or, 3 xor, 4 shl, 5 shr, 6 rol, 7 ror) |
| acc_i | input | DW | Accumulator value |
| opnd_i | input | DW | Second operand |
| st_i | input | 8 | Incoming status byte |
| res_o | output | DW | Registered result |
| st_o | output | 8 | Registered updated status byte |

## Verification
Directed sums cover the signed-overflow corners:
- 0x7F+0x01 overflows positively.
- 0x80+0x80 overflows negatively and wraps to zero with carry.
- 0xFF+0x00 with carry in wraps to zero without overflow.

Together these separate carry from overflow and check zero detection on a wrapped result. The shift and rotate cases use a single set bit at the exiting end, which separates a shift from a rotate and shows whether the carry moves in the right direction.

Random operations run with status bytes that are all-ones, all-zeros or random. This shows that untouched bits are really passed through and not forced to a constant, and that a random operand leaves the shifts unchanged.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int SW = 8;

    localparam int FLG_N = 7;
    localparam int FLG_V = 6;
    localparam int FLG_Z = 1;
    localparam int FLG_C = 0;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_AND = 3'd1,
        OP_OR  = 3'd2,
        OP_XOR = 3'd3,
        OP_SHL = 3'd4,
        OP_SHR = 3'd5,
        OP_RTL = 3'd6,
        OP_RTR = 3'd7
    } alu_op_e;

    // Which status bits an operation is allowed to rewrite
    function automatic logic [SW-1:0] flag_mask(alu_op_e op);
        logic [SW-1:0] m;
        m = '0;
        m[FLG_N] = 1'b1;
        m[FLG_Z] = 1'b1;
        case (op)
            OP_ADD: begin
                m[FLG_V] = 1'b1;
                m[FLG_C] = 1'b1;
            end
            OP_SHL, OP_SHR, OP_RTL, OP_RTR: m[FLG_C] = 1'b1;
            default: ;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    output logic [DW-1:0] sum_o,
    output logic          cout_o,
    output logic          ovf_o
);
    logic [DW:0] wide;

    always_comb begin
        wide   = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
        sum_o  = wide[DW-1:0];
        cout_o = wide[DW];
        // two's-complement overflow: like-signed inputs, opposite-signed sum
        ovf_o  = (a_i[DW-1] == b_i[DW-1]) && (sum_o[DW-1] != a_i[DW-1]);
    end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
    parameter int DW = 8
) (
    input  acc_alu_pkg::alu_op_e op_i,
    input  logic [DW-1:0]        a_i,
    input  logic [DW-1:0]        b_i,
    output logic [DW-1:0]        res_o
);
    import acc_alu_pkg::*;

    always_comb begin
        case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift #(
    parameter int DW = 8
) (
    input  acc_alu_pkg::alu_op_e op_i,
    input  logic [DW-1:0]        a_i,
    input  logic                 cin_i,
    output logic [DW-1:0]        res_o,
    output logic                 cout_o
);
    import acc_alu_pkg::*;

    logic fill;
    logic leftward;

    always_comb begin
        leftward = (op_i == OP_SHL) || (op_i == OP_RTL);
        fill     = ((op_i == OP_RTL) || (op_i == OP_RTR)) ? cin_i : 1'b0;
        if (leftward) begin
            res_o  = {a_i[DW-2:0], fill};
            cout_o = a_i[DW-1];
        end else begin
            res_o  = {fill, a_i[DW-1:1]};
            cout_o = a_i[0];
        end
    end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags #(
    parameter int DW = 8
) (
    input  acc_alu_pkg::alu_op_e               op_i,
    input  logic [DW-1:0]                      res_i,
    input  logic                               carry_i,
    input  logic                               ovf_i,
    input  logic [acc_alu_pkg::SW-1:0]         st_i,
    output logic [acc_alu_pkg::SW-1:0]         st_o
);
    import acc_alu_pkg::*;

    logic [SW-1:0] fresh;
    logic [SW-1:0] mask;

    always_comb begin
        fresh        = '0;
        fresh[FLG_N] = res_i[DW-1];
        fresh[FLG_V] = ovf_i;
        fresh[FLG_Z] = (res_i == '0);
        fresh[FLG_C] = carry_i;
        mask         = flag_mask(op_i);
    end

    for (genvar i = 0; i < SW; i++) begin : g_merge
        assign st_o[i] = mask[i] ? fresh[i] : st_i[i];
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
    parameter int DW = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 op_i,
    input  logic [DW-1:0]              acc_i,
    input  logic [DW-1:0]              opnd_i,
    input  logic [acc_alu_pkg::SW-1:0] st_i,
    output logic [DW-1:0]              res_o,
    output logic [acc_alu_pkg::SW-1:0] st_o
);
    import acc_alu_pkg::*;

    typedef struct packed {
        logic [DW-1:0] res;
        logic [SW-1:0] st;
    } alu_reg_t;

    alu_op_e       op;
    logic [DW-1:0] add_res, log_res, sh_res, sel_res;
    logic          add_c, add_v, sh_c, sel_c;
    logic [SW-1:0] st_new;
    alu_reg_t      r_d, r_q;

    assign op = alu_op_e'(op_i);

    acc_alu_adder #(.DW(DW)) u_add (
        .a_i(acc_i), .b_i(opnd_i), .cin_i(st_i[FLG_C]),
        .sum_o(add_res), .cout_o(add_c), .ovf_o(add_v)
    );

    acc_alu_logic #(.DW(DW)) u_log (
        .op_i(op), .a_i(acc_i), .b_i(opnd_i), .res_o(log_res)
    );

    acc_alu_shift #(.DW(DW)) u_sh (
        .op_i(op), .a_i(acc_i), .cin_i(st_i[FLG_C]),
        .res_o(sh_res), .cout_o(sh_c)
    );

    always_comb begin
        if (op == OP_ADD) begin
            sel_res = add_res;
            sel_c   = add_c;
        end else if (op_i[2]) begin
            sel_res = sh_res;
            sel_c   = sh_c;
        end else begin
            sel_res = log_res;
            sel_c   = 1'b0;
        end
    end

    acc_alu_flags #(.DW(DW)) u_flg (
        .op_i(op), .res_i(sel_res), .carry_i(sel_c), .ovf_i(add_v),
        .st_i(st_i), .st_o(st_new)
    );

    always_comb begin
        r_d.res = sel_res;
        r_d.st  = st_new;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign res_o = r_q.res;
    assign st_o  = r_q.st;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    op_i,
    input logic [DW-1:0] acc_i,
    input logic [DW-1:0] opnd_i,
    input logic [7:0]    st_i,
    input logic [DW-1:0] res_q,
    input logic [7:0]    st_q
);
    // set once a real sample has been captured after reset
    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    a_r9_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (st_q[1] == (res_q == '0)));

    a_r9_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (st_q[7] == res_q[DW-1]));

    a_r10_mid_bits_pass: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (st_q[5:2] == $past(st_i[5:2])));

    a_r5_logic_keeps_vc: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && ($past(op_i) inside {3'd1, 3'd2, 3'd3}))
        |-> (st_q[6] == $past(st_i[6]) && st_q[0] == $past(st_i[0])));

    a_r4_add_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == 3'd0)
        |-> (st_q[6] == (($past(acc_i[DW-1]) == $past(opnd_i[DW-1]))
                         && (res_q[DW-1] != $past(acc_i[DW-1])))));

    a_r6_shl_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == 3'd4)
        |-> (st_q[0] == $past(acc_i[DW-1]) && res_q[0] == 1'b0));

    a_r7_shr_n_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == 3'd5) |-> (st_q[7] == 1'b0));
endmodule

bind acc_alu acc_alu_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
    .st_i(st_i), .res_q(res_o), .st_q(st_o)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_i = '0;
    logic [7:0] acc_i = '0, opnd_i = '0, st_i = '0;
    logic [7:0] res_o, st_o;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    acc_alu #(.DW(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i),
        .opnd_i(opnd_i), .st_i(st_i), .res_o(res_o), .st_o(st_o)
    );

    // expected {status, result} from the requirements
    function automatic logic [15:0] model(logic [2:0] op, logic [7:0] a,
                                          logic [7:0] b, logic [7:0] s);
        logic [8:0] w;
        logic [7:0] r, ns;
        ns = s;
        case (op)
            3'd0: begin
                w = {1'b0, a} + {1'b0, b} + {8'd0, s[0]};
                r = w[7:0];
                ns[0] = w[8];
                ns[6] = (a[7] == b[7]) && (r[7] != a[7]);
            end
            3'd1: r = a & b;
            3'd2: r = a | b;
            3'd3: r = a ^ b;
            3'd4: begin r = {a[6:0], 1'b0}; ns[0] = a[7]; end
            3'd5: begin r = {1'b0, a[7:1]}; ns[0] = a[0]; end
            3'd6: begin r = {a[6:0], s[0]}; ns[0] = a[7]; end
            default: begin r = {s[0], a[7:1]}; ns[0] = a[0]; end
        endcase
        ns[7] = r[7];
        ns[1] = (r == 8'd0);
        return {ns, r};
    endfunction

    function automatic string op_tag(logic [2:0] op);
        case (op)
            3'd0: return "R3/R4/R9";
            3'd1, 3'd2, 3'd3: return "R5/R9/R10";
            3'd4: return "R6/R10";
            3'd5: return "R7/R10";
            default: return "R8/R10";
        endcase
    endfunction

    task automatic run_op(logic [2:0] op, logic [7:0] a, logic [7:0] b,
                          logic [7:0] s, string tag);
        logic [15:0] exp;
        @(negedge clk);
        op_i = op; acc_i = a; opnd_i = b; st_i = s;
        exp = model(op, a, b, s);
        @(posedge clk);
        #1;
        checks++;
        if ({st_o, res_o} !== exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h s=%h: got st=%h res=%h, exp st=%h res=%h",
                     tag, op, a, b, s, st_o, res_o, exp[15:8], exp[7:0]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        op_i = 3'd0; acc_i = 8'h7F; opnd_i = 8'h01; st_i = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        checks++;   // R1 reset state with live inputs
        if (res_o !== 8'h00 || st_o !== 8'h00) begin
            errors++;
            $display("FAIL R1 reset: got st=%h res=%h, exp st=00 res=00", st_o, res_o);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2: result appears one edge after inputs
        run_op(3'd1, 8'hF0, 8'h3C, 8'h00, "R2");
        // R3/R4 add corners
        run_op(3'd0, 8'h7F, 8'h01, 8'h00, "R4 positive overflow");
        run_op(3'd0, 8'h80, 8'h80, 8'h00, "R3/R4 negative overflow wrap");
        run_op(3'd0, 8'hFF, 8'h00, 8'h01, "R3 carry-in wrap");
        run_op(3'd0, 8'h10, 8'h20, 8'hC0, "R4 V cleared");
        // R5 logic keeps V and C
        run_op(3'd1, 8'hAA, 8'h55, 8'h41, "R5 and zero");
        run_op(3'd3, 8'hFF, 8'h0F, 8'hFF, "R5 xor");
        run_op(3'd2, 8'h00, 8'h80, 8'h00, "R5 or");
        // R6/R7/R8 shift/rotate corners, operand ignored
        run_op(3'd4, 8'h80, 8'hFF, 8'h3C, "R6 shl out");
        run_op(3'd5, 8'h01, 8'hFF, 8'hFF, "R7 shr out");
        run_op(3'd6, 8'h80, 8'h5A, 8'h00, "R8 rol no cin");
        run_op(3'd6, 8'h00, 8'h00, 8'h01, "R8 rol cin");
        run_op(3'd7, 8'h00, 8'h00, 8'h01, "R8 ror cin");
        run_op(3'd7, 8'h01, 8'hA5, 8'h00, "R8 ror out");

        for (int i = 0; i < 400; i++) begin
            logic [2:0] op;
            logic [7:0] a, b, s;
            op = 3'($urandom_range(0, 7));
            a  = 8'($urandom);
            b  = 8'($urandom);
            case ($urandom_range(0, 2))
                0: s = 8'hFF;
                1: s = 8'h00;
                default: s = 8'($urandom);
            endcase
            run_op(op, a, b, s, op_tag(op));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule